// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block decides, for one executing load, whether its data can come straight from an older store still held in the store queue, whether it must wait because an older store covers only some of its bytes, or whether it should go to the data cache. The caller presents the load's byte address, byte size and sequence tag. The block sees every store queue entry at once through a flattened read port. It compares the load against each entry in parallel and lets the youngest older store that overlaps the load decide the outcome. A store that covers the whole load forwards its data, shifted down to the load's byte offset and trimmed to the load's size. A store that overlaps only part of the load stalls the load if it has not yet been written back. If it has been written back, the load goes to the cache.

The block also holds one stall record. It names the oldest load that was stalled by a partial overlap and the tag of the store that blocked it. When the store completion port reports that store's tag, the record clears and the block raises a one-cycle replay pulse that carries the stalled load's tag.

Load requests use a valid/ready handshake. Results leave through a one-deep registered valid/ready stage. A request is accepted whenever the result register is empty or its current result is being taken in the same cycle. While `res_valid` is high and `res_ready` is low, the result is held unchanged and `req_ready` stays low. The store read port, the completion port and the stall and replay outputs are plain signals with no handshake.

Top module: `store_fwd_check`

## Requirements
- R1: A store entry is considered only if its valid bit is set, its size is nonzero, and its tag is strictly below the load tag, with tags compared as plain unsigned numbers.
- R2: Among the considered entries whose byte range [addr, addr+size) intersects the load's range, the one with the largest tag alone decides the outcome. Older overlapping entries have no effect.
- R3: If the deciding store covers the whole load (load addr >= store addr and load addr + load size <= store addr + store size), the result kind is 1 (forward). The result data is the store data shifted right by 8 × (load addr AND (store size − 1)) bits, with every byte at or above the load size cleared.
- R4: If the deciding store overlaps only partly and its completed bit is clear, the result kind is 2 (stall).
- R5: If the deciding store overlaps only partly and its completed bit is set, the result kind is 0 (cache) and older stores are not examined.
- R6: If no considered store overlaps the load (touching ranges do not overlap), the result kind is 0 (cache) and the result data is 0.
- R7: An accepted request produces `res_valid` on the next cycle. While `res_ready` is low, the result is held stable and `req_ready` is low.
- R8: A stall outcome loads the stall record (store tag, load tag) only when the record is idle or the new load's tag is below the recorded load tag.
- R9: A completion whose tag equals the recorded store tag clears the record on the next cycle and raises `replay_valid` for exactly that cycle, with `replay_tag` set to the recorded load tag. A completion with any other tag changes nothing.
- R10: After reset, `res_valid`, `stall_active` and `replay_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Load request accepted this cycle when high with req_valid |
| req_addr | input | ADDR_W | Load byte address |
| req_size | input | SIZE_W | Load size in bytes (1 to DATA_W/8) |
| req_tag | input | TAG_W | Load sequence tag |
| sq_valid | input | SQ_DEPTH | Per-entry valid bits |
| sq_tag | input | SQ_DEPTH*TAG_W | Per-entry store tags, entry i at bits [i*TAG_W +: TAG_W] |
| sq_addr | input | SQ_DEPTH*ADDR_W | Per-entry store byte addresses |
| sq_size | input | SQ_DEPTH*SIZE_W | Per-entry store sizes, 0 while data is not yet written |
| sq_data | input | SQ_DEPTH*DATA_W | Per-entry store data, byte 0 at bits [7:0] |
| sq_done | input | SQ_DEPTH | Per-entry completed (written back) bits |
| done_valid | input | 1 | A store has completed this cycle |
| done_tag | input | TAG_W | Tag of the completing store |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_kind | output | 2 | 0 cache, 1 forward, 2 stall |
| res_tag | output | TAG_W | Tag of the load the result belongs to |
| res_data | output | DATA_W | Forwarded data for kind 1, otherwise 0 |
| stall_active | output | 1 | Stall record holds a load |
| stall_store_tag | output | TAG_W | Tag of the blocking store |
| stall_load_tag | output | TAG_W | Tag of the recorded stalled load |
| replay_valid | output | 1 | One-cycle replay pulse for the recorded load |
| replay_tag | output | TAG_W | Tag of the load to replay |

## Verification
On every cycle the assertions check the result handshake: an accepted request yields a result on the next cycle, and a held result does not change. They also check the stall record. It is only ever replaced by an older load, it clears with a replay pulse after the matching completion, and the replay carries the load tag that had been recorded. Which store wins the age race, the shifted and trimmed forward data, skipping of empty and younger entries, the completed-store shortcut, and boundaries where ranges only touch all depend on particular store queue contents. These are shown only by the bench's directed scenarios.

// File: rtl/stfwd_pkg.sv
package stfwd_pkg;
  typedef enum logic [1:0] {
    RES_CACHE = 2'd0,
    RES_FWD   = 2'd1,
    RES_STALL = 2'd2
  } res_kind_e;
endpackage

// File: rtl/stfwd_entry_cmp.sv
// Compares one store queue entry against the load: eligibility, overlap,
// full coverage and the data shifted to the load's byte offset.
module stfwd_entry_cmp #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 8,
  parameter int SIZE_W = 4
) (
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [ADDR_W-1:0] ent_addr,
  input  logic [SIZE_W-1:0] ent_size,
  input  logic [DATA_W-1:0] ent_data,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SIZE_W-1:0] ld_size,
  input  logic [TAG_W-1:0]  ld_tag,
  output logic              cand,
  output logic              full_cov,
  output logic [DATA_W-1:0] shifted
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [ADDR_W:0] st_lo, st_hi, ld_lo, ld_hi;
  logic            eligible, overlap;
  logic [OFF_W-1:0] off;

  always_comb begin
    st_lo = {1'b0, ent_addr};
    st_hi = st_lo + (ADDR_W+1)'(ent_size);
    ld_lo = {1'b0, ld_addr};
    ld_hi = ld_lo + (ADDR_W+1)'(ld_size);
    eligible = ent_valid && (ent_size != '0) && (ent_tag < ld_tag);
    overlap  = (ld_lo < st_hi) && (ld_hi > st_lo);
    cand     = eligible && overlap;
    full_cov = (ld_lo >= st_lo) && (ld_hi <= st_hi);
    off      = ld_addr[OFF_W-1:0] & (ent_size[OFF_W-1:0] - OFF_W'(1));
    shifted  = ent_data >> {off, 3'b000};
  end
endmodule

// File: rtl/stfwd_age_pick.sv
// Age-priority select: the candidate with the largest tag wins.
module stfwd_age_pick #(
  parameter int N     = 8,
  parameter int TAG_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]       cand,
  input  logic [N*TAG_W-1:0] tags,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  logic [TAG_W-1:0] best;

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!hit || tags[i*TAG_W +: TAG_W] > best)) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        best = tags[i*TAG_W +: TAG_W];
      end
    end
  end
endmodule

// File: rtl/stfwd_stall_track.sv
// Single stall record: oldest partially blocked load and its blocking store.
module stfwd_stall_track #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_req,
  input  logic [TAG_W-1:0] new_ld_tag,
  input  logic [TAG_W-1:0] new_st_tag,
  input  logic             done_valid,
  input  logic [TAG_W-1:0] done_tag,
  output logic             active,
  output logic [TAG_W-1:0] st_tag,
  output logic [TAG_W-1:0] ld_tag,
  output logic             replay_valid,
  output logic [TAG_W-1:0] replay_tag
);
  logic clear_hit, live_after, take;

  always_comb begin
    clear_hit  = active && done_valid && (done_tag == st_tag);
    live_after = active && !clear_hit;
    take       = set_req && (!live_after || (new_ld_tag < ld_tag));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active       <= 1'b0;
      st_tag       <= '0;
      ld_tag       <= '0;
      replay_valid <= 1'b0;
      replay_tag   <= '0;
    end else begin
      replay_valid <= clear_hit;
      if (clear_hit) replay_tag <= ld_tag;
      if (take) begin
        active <= 1'b1;
        st_tag <= new_st_tag;
        ld_tag <= new_ld_tag;
      end else if (clear_hit) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/store_fwd_check.sv
module store_fwd_check #(
  parameter int SQ_DEPTH = 8,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 8,
  localparam int BYTES   = DATA_W / 8,
  localparam int SIZE_W  = $clog2(BYTES) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [SIZE_W-1:0]      req_size,
  input  logic [TAG_W-1:0]       req_tag,
  input  logic [SQ_DEPTH-1:0]    sq_valid,
  input  logic [SQ_DEPTH*TAG_W-1:0]  sq_tag,
  input  logic [SQ_DEPTH*ADDR_W-1:0] sq_addr,
  input  logic [SQ_DEPTH*SIZE_W-1:0] sq_size,
  input  logic [SQ_DEPTH*DATA_W-1:0] sq_data,
  input  logic [SQ_DEPTH-1:0]    sq_done,
  input  logic                   done_valid,
  input  logic [TAG_W-1:0]       done_tag,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [1:0]             res_kind,
  output logic [TAG_W-1:0]       res_tag,
  output logic [DATA_W-1:0]      res_data,
  output logic                   stall_active,
  output logic [TAG_W-1:0]       stall_store_tag,
  output logic [TAG_W-1:0]       stall_load_tag,
  output logic                   replay_valid,
  output logic [TAG_W-1:0]       replay_tag
);
  import stfwd_pkg::*;
  localparam int IDX_W = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1;

  logic [SQ_DEPTH-1:0] cand, full_cov;
  logic [DATA_W-1:0]   shifted [SQ_DEPTH];
  logic                hit;
  logic [IDX_W-1:0]    win;

  for (genvar g = 0; g < SQ_DEPTH; g++) begin : g_ent
    stfwd_entry_cmp #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .SIZE_W(SIZE_W)
    ) u_cmp (
      .ent_valid(sq_valid[g]),
      .ent_tag  (sq_tag [g*TAG_W  +: TAG_W]),
      .ent_addr (sq_addr[g*ADDR_W +: ADDR_W]),
      .ent_size (sq_size[g*SIZE_W +: SIZE_W]),
      .ent_data (sq_data[g*DATA_W +: DATA_W]),
      .ld_addr  (req_addr),
      .ld_size  (req_size),
      .ld_tag   (req_tag),
      .cand     (cand[g]),
      .full_cov (full_cov[g]),
      .shifted  (shifted[g])
    );
  end

  stfwd_age_pick #(.N(SQ_DEPTH), .TAG_W(TAG_W)) u_pick (
    .cand(cand), .tags(sq_tag), .hit(hit), .idx(win)
  );

  res_kind_e         kind_d;
  logic [DATA_W-1:0] data_d, byte_mask;
  logic              accept;

  always_comb begin
    for (int b = 0; b < BYTES; b++)
      byte_mask[b*8 +: 8] = (SIZE_W'(b) < req_size) ? 8'hFF : 8'h00;
    kind_d = RES_CACHE;
    data_d = '0;
    if (hit) begin
      if (full_cov[win]) begin
        kind_d = RES_FWD;
        data_d = shifted[win] & byte_mask;
      end else if (!sq_done[win]) begin
        kind_d = RES_STALL;
      end
    end
  end

  assign req_ready = !res_valid || res_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_kind  <= RES_CACHE;
      res_tag   <= '0;
      res_data  <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_kind  <= kind_d;
      res_tag   <= req_tag;
      res_data  <= data_d;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  stfwd_stall_track #(.TAG_W(TAG_W)) u_stall (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_req     (accept && (kind_d == RES_STALL)),
    .new_ld_tag  (req_tag),
    .new_st_tag  (sq_tag[win*TAG_W +: TAG_W]),
    .done_valid  (done_valid),
    .done_tag    (done_tag),
    .active      (stall_active),
    .st_tag      (stall_store_tag),
    .ld_tag      (stall_load_tag),
    .replay_valid(replay_valid),
    .replay_tag  (replay_tag)
  );
endmodule

// File: rtl/store_fwd_check_chk.sv
module store_fwd_check_chk #(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [1:0]        res_kind,
  input logic [DATA_W-1:0] res_data,
  input logic              stall_active,
  input logic [TAG_W-1:0]  stall_store_tag,
  input logic [TAG_W-1:0]  stall_load_tag,
  input logic              done_valid,
  input logic [TAG_W-1:0]  done_tag,
  input logic              replay_valid,
  input logic [TAG_W-1:0]  replay_tag
);
  // R7
  accept_gives_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> res_valid);
  // R7
  held_result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_kind) && $stable(res_data));
  // R7
  no_accept_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !req_ready);
  // R4
  stall_set_by_stall_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_active) |-> res_valid && res_kind == 2'd2);
  // R8
  record_only_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_active && $past(stall_active) && !replay_valid &&
    stall_load_tag != $past(stall_load_tag) |-> stall_load_tag < $past(stall_load_tag));
  // R9
  completion_replays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_active && done_valid && done_tag == stall_store_tag |=> replay_valid);
  // R9
  replay_tag_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> $past(stall_active) && replay_tag == $past(stall_load_tag));
endmodule

bind store_fwd_check store_fwd_check_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_kind(res_kind),
  .res_data(res_data), .stall_active(stall_active),
  .stall_store_tag(stall_store_tag), .stall_load_tag(stall_load_tag),
  .done_valid(done_valid), .done_tag(done_tag),
  .replay_valid(replay_valid), .replay_tag(replay_tag)
);

// File: tb/tb_store_fwd_check.sv
module tb_store_fwd_check;
  localparam int N = 8, AW = 16, DW = 64, TW = 8, SW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, res_ready = 1'b1, done_valid = 1'b0;
  logic          req_ready, res_valid, stall_active, replay_valid;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_size = '0;
  logic [TW-1:0] req_tag = '0, done_tag = '0;
  logic [N-1:0]  sq_valid = '0, sq_done = '0;
  logic [N*TW-1:0] sq_tag = '0;
  logic [N*AW-1:0] sq_addr = '0;
  logic [N*SW-1:0] sq_size = '0;
  logic [N*DW-1:0] sq_data = '0;
  logic [1:0]    res_kind;
  logic [TW-1:0] res_tag, stall_store_tag, stall_load_tag, replay_tag;
  logic [DW-1:0] res_data;

  store_fwd_check #(.SQ_DEPTH(N), .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW)) dut (.*);

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int i, input logic [TW-1:0] t, input logic [AW-1:0] a,
                     input logic [SW-1:0] s, input logic [DW-1:0] d, input bit dn);
    sq_valid[i] = 1'b1; sq_tag[i*TW +: TW] = t; sq_addr[i*AW +: AW] = a;
    sq_size[i*SW +: SW] = s; sq_data[i*DW +: DW] = d; sq_done[i] = dn;
  endtask

  task automatic clear_q();
    sq_valid = '0; sq_done = '0; sq_size = '0;
  endtask

  // drive one load at a negedge; returns after the result edge, at the next negedge
  task automatic issue(input logic [AW-1:0] a, input logic [SW-1:0] s, input logic [TW-1:0] t);
    @(negedge clk);
    req_addr = a; req_size = s; req_tag = t; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(res_valid == 0, "R10 res_valid", res_valid, 0);
    chk(stall_active == 0, "R10 stall_active", stall_active, 0);
    chk(replay_valid == 0, "R10 replay_valid", replay_valid, 0);
    chk(req_ready == 1, "R10 req_ready", req_ready, 1);
  endtask

  task automatic t_full_cover();
    clear_q();
    put(0, 8'd5, 16'h0100, 4'd8, 64'h8877665544332211, 0);
    issue(16'h0102, 4'd2, 8'd9);
    chk(res_valid == 1, "R7 result next cycle", res_valid, 1);
    chk(res_kind == 2'd1, "R3 kind forward", res_kind, 1);
    chk(res_data == 64'h4433, "R3 shifted data", res_data, 64'h4433);
    chk(res_tag == 8'd9, "R7 result tag", res_tag, 9);
  endtask

  task automatic t_age_priority();
    clear_q();
    put(0, 8'd3,  16'h0100, 4'd8, 64'h1111111111111111, 0);
    put(1, 8'd6,  16'h0100, 4'd4, 64'h00000000AABBCCDD, 0);
    put(2, 8'd12, 16'h0100, 4'd8, 64'h3333333333333333, 0);
    put(3, 8'd8,  16'h0100, 4'd0, 64'h4444444444444444, 0);
    issue(16'h0102, 4'd2, 8'd9);
    chk(res_kind == 2'd1, "R2 kind forward", res_kind, 1);
    chk(res_data == 64'hAABB, "R2 R1 youngest older sized store wins", res_data, 64'hAABB);
  endtask

  task automatic t_no_overlap();
    clear_q();
    put(0, 8'd1, 16'h0200, 4'd8, 64'hFFFF, 0);
    issue(16'h01FC, 4'd4, 8'd5);
    chk(res_kind == 2'd0, "R6 touching ranges go to cache", res_kind, 0);
    chk(res_data == 64'd0, "R6 cache data zero", res_data, 0);
  endtask

  task automatic t_partial_done();
    clear_q();
    put(0, 8'd2, 16'h0100, 4'd8, 64'h5555, 0);
    put(1, 8'd7, 16'h0104, 4'd4, 64'h6666, 1);
    issue(16'h0100, 4'd8, 8'd9);
    chk(res_kind == 2'd0, "R5 completed partial goes to cache", res_kind, 0);
    chk(stall_active == 0, "R5 no stall recorded", stall_active, 0);
  endtask

  task automatic t_partial_stall();
    sq_done[1] = 1'b0;
    issue(16'h0100, 4'd8, 8'd9);
    chk(res_kind == 2'd2, "R4 kind stall", res_kind, 2);
    chk(stall_active == 1, "R4 record set", stall_active, 1);
    chk(stall_store_tag == 8'd7, "R4 store tag", stall_store_tag, 7);
    chk(stall_load_tag == 8'd9, "R4 load tag", stall_load_tag, 9);
  endtask

  task automatic t_oldest_kept();
    issue(16'h0100, 4'd8, 8'd12);
    chk(res_kind == 2'd2, "R8 younger still stalls", res_kind, 2);
    chk(stall_load_tag == 8'd9, "R8 younger does not replace", stall_load_tag, 9);
    issue(16'h0100, 4'd8, 8'd8);
    chk(stall_load_tag == 8'd8, "R8 older replaces", stall_load_tag, 8);
  endtask

  task automatic t_completion();
    @(negedge clk); done_valid = 1'b1; done_tag = 8'd99;
    @(negedge clk); done_valid = 1'b0;
    chk(stall_active == 1, "R9 other tag ignored", stall_active, 1);
    chk(replay_valid == 0, "R9 no replay on other tag", replay_valid, 0);
    done_valid = 1'b1; done_tag = 8'd7;
    @(negedge clk); done_valid = 1'b0;
    chk(replay_valid == 1, "R9 replay pulse", replay_valid, 1);
    chk(replay_tag == 8'd8, "R9 replay tag", replay_tag, 8);
    chk(stall_active == 0, "R9 record cleared", stall_active, 0);
    @(negedge clk);
    chk(replay_valid == 0, "R9 pulse one cycle", replay_valid, 0);
  endtask

  task automatic t_backpressure();
    clear_q();
    put(0, 8'd5, 16'h0100, 4'd8, 64'h8877665544332211, 0);
    @(negedge clk); res_ready = 1'b0;
    issue(16'h0104, 4'd4, 8'd9);
    chk(res_valid == 1 && res_data == 64'h88776655, "R7 R3 result present", res_data, 64'h88776655);
    chk(req_ready == 0, "R7 not ready while held", req_ready, 0);
    @(negedge clk);
    chk(res_valid == 1 && res_data == 64'h88776655, "R7 result held", res_data, 64'h88776655);
    res_ready = 1'b1;
    @(negedge clk);
    chk(res_valid == 0, "R7 result drained", res_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_cover();
    t_age_priority();
    t_no_overlap();
    t_partial_done();
    t_partial_stall();
    t_oldest_kept();
    t_completion();
    t_backpressure();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule